// File: doc/BRIEF.md
# Load-Store Dependence Predictor

This block decides, for every load leaving the scheduler, whether that load may run ahead of older stores whose addresses are still unknown. A table of saturating confidence counters is indexed by a hash of the load's instruction pointer. A load is allowed to bypass unresolved stores only when its counter is at the maximum. All other loads that meet an unknown older store are held in a small load buffer. They are released once no store in flight has an unknown address.

Each buffered load carries its own status bits: under disambiguation, needs training, executed speculatively, and conflict seen. When a store resolves its address, it searches the buffer. A speculatively executed load with the same address that is younger than the store is marked as a conflict, and a violation pulse names its slot. When a load commits, its counter is trained if the load met an unknown store. A conflict clears the counter to zero. A clean outcome raises the counter by one and holds it at the maximum. The pipeline flush, store forwarding and the data cache lie outside the block.

Top module: `memdep_pred`

## Requirements
- R1: After reset every counter is zero and the buffer is empty. `ld_rdy` is 1, `ld_slot` is 0, `rel_valid` and `viol_valid` are 0, and a load with `ld_older_unk`=1 gets `ld_go`=0.
- R2: The table index is `ld_ip[5:0] ^ ld_ip[11:6]`. Two IPs with the same index share one counter.
- R3: A load issued with `ld_older_unk`=0 gets `ld_go`=1 in the same cycle. Its commit leaves its counter unchanged.
- R4: A load with `ld_older_unk`=1 and a counter below 15 gets `ld_go`=0 and is blocked. While `st_all_known`=1, `rel_valid` is asserted in the same cycle for the lowest-numbered blocked slot. One slot is released per cycle, and nothing is released while `st_all_known`=0.
- R5: A load with `ld_older_unk`=1 and a counter of 15 gets `ld_go`=1 in its issue cycle.
- R6: A commit of a load that met an unknown store and saw no conflict raises its counter by one. A counter at 15 stays at 15.
- R7: A store resolve compares `st_addr` with every buffered load that executed with `ld_go`=1 while meeting an unknown store, and whose bit in `st_ld_mask` is 1. Any hit marks that load, and in the next cycle `viol_valid` is high for one cycle with `viol_slot` set to the lowest hit slot. A load whose address differs, whose mask bit is 0, or that was blocked is neither marked nor reported.
- R8: A commit of a load marked by R7 clears its counter to zero.
- R9: A new load takes the lowest free slot. `ld_rdy` is 0 when all 8 slots are in use. A commit frees its slot from the next cycle.
- R10: Counters change only at commit. A load issued in the same cycle as a commit that trains its counter sees the old counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load leaves the scheduler this cycle |
| ld_ip | input | 12 | Low bits of the load's instruction pointer |
| ld_addr | input | 32 | Load address |
| ld_older_unk | input | 1 | Some older store has an unknown address |
| ld_rdy | output | 1 | A buffer slot is free |
| ld_slot | output | 3 | Slot the load is written into |
| ld_go | output | 1 | Load may execute now |
| st_all_known | input | 1 | No store in flight has an unknown address |
| rel_valid | output | 1 | A blocked load is released this cycle |
| rel_slot | output | 3 | Slot of the released load |
| st_valid | input | 1 | A store resolves its address this cycle |
| st_addr | input | 32 | Resolved store address |
| st_ld_mask | input | 8 | Slots holding loads younger than this store |
| cm_valid | input | 1 | A buffered load commits |
| cm_slot | input | 3 | Slot of the committing load |
| viol_valid | output | 1 | One-cycle ordering violation pulse |
| viol_slot | output | 3 | Slot of the violating load |

## Verification
A counter that is corrupted or left untrained first shows at the ports on the next issue of a load with the same hash, as a wrong `ld_go` in that issue cycle. The bench therefore trains counters up to their edges and probes them with issues. A lost or stray status bit in the buffer shows either as a missing or spurious `viol_valid` one cycle after the store resolve, or as a wrong `ld_go` on the next issue after the load's commit. A broken slot pointer shows at once on `ld_slot`, `rel_slot` or `ld_rdy`.

// File: rtl/ldp_pkg.sv
`timescale 1ns/1ps
package ldp_pkg;
  localparam int LDP_IP_W   = 12;
  localparam int LDP_IDX_W  = 6;
  localparam int LDP_CNT_W  = 4;
  localparam int LDP_LB_N   = 8;
  localparam int LDP_ADDR_W = 32;
endpackage

// File: rtl/ldp_table.sv
`timescale 1ns/1ps
module ldp_table #(
  parameter int IP_W  = ldp_pkg::LDP_IP_W,
  parameter int IDX_W = ldp_pkg::LDP_IDX_W,
  parameter int CNT_W = ldp_pkg::LDP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IP_W-1:0]  rd_ip,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_sat,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_clear
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] conf_q [ENTRIES];

  // fold the two low IP chunks into one table index
  function automatic logic [IDX_W-1:0] fold_ip(input logic [IP_W-1:0] ip);
    return ip[IDX_W-1:0] ^ ip[2*IDX_W-1:IDX_W];
  endfunction

  // saturating increment
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  assign rd_idx = fold_ip(rd_ip);
  assign rd_sat = (conf_q[rd_idx] == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) conf_q[i] <= '0;
    end else if (wr_en) begin
      conf_q[wr_idx] <= wr_clear ? '0 : bump(conf_q[wr_idx]);
    end
  end
endmodule

// File: rtl/ldp_lbuf.sv
`timescale 1ns/1ps
module ldp_lbuf #(
  parameter int LB_N   = ldp_pkg::LDP_LB_N,
  parameter int ADDR_W = ldp_pkg::LDP_ADDR_W,
  parameter int IDX_W  = ldp_pkg::LDP_IDX_W,
  localparam int SLOT_W = $clog2(LB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [IDX_W-1:0]  alloc_hidx,
  input  logic              alloc_unk,
  input  logic              alloc_go,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  input  logic              rel_en,
  output logic              rel_valid,
  output logic [SLOT_W-1:0] rel_slot,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LB_N-1:0]   st_mask,
  output logic              viol_valid,
  output logic [SLOT_W-1:0] viol_slot,
  input  logic              cm_valid,
  input  logic [SLOT_W-1:0] cm_slot,
  output logic              cm_update,
  output logic              cm_conflict,
  output logic [IDX_W-1:0]  cm_hidx
);
  logic [LB_N-1:0]   live_q, upd_q, spec_q, blk_q, clash_q;
  logic [ADDR_W-1:0] addr_q [LB_N];
  logic [IDX_W-1:0]  hidx_q [LB_N];
  logic [LB_N-1:0]   hit;

  function automatic logic [SLOT_W-1:0] first_one(input logic [LB_N-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = LB_N - 1; i >= 0; i--) if (v[i]) r = SLOT_W'(i);
    return r;
  endfunction

  // store search: one comparator per slot
  for (genvar g = 0; g < LB_N; g++) begin : g_cmp
    assign hit[g] = st_valid && live_q[g] && spec_q[g] && st_mask[g] &&
                    (addr_q[g] == st_addr);
  end

  assign free_any    = ~&live_q;
  assign free_slot   = first_one(~live_q);
  assign rel_valid   = rel_en && (|blk_q);
  assign rel_slot    = first_one(blk_q);
  assign cm_update   = upd_q[cm_slot];
  assign cm_conflict = clash_q[cm_slot];
  assign cm_hidx     = hidx_q[cm_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0; upd_q <= '0; spec_q <= '0; blk_q <= '0; clash_q <= '0;
      viol_valid <= 1'b0;
      viol_slot  <= '0;
      for (int i = 0; i < LB_N; i++) begin
        addr_q[i] <= '0;
        hidx_q[i] <= '0;
      end
    end else begin
      viol_valid <= |hit;
      viol_slot  <= first_one(hit);
      clash_q    <= clash_q | hit;
      if (rel_valid) blk_q[rel_slot] <= 1'b0;
      if (alloc_en) begin
        live_q[free_slot]  <= 1'b1;
        upd_q[free_slot]   <= alloc_unk;
        spec_q[free_slot]  <= alloc_unk && alloc_go;
        blk_q[free_slot]   <= alloc_unk && !alloc_go;
        clash_q[free_slot] <= 1'b0;
        addr_q[free_slot]  <= alloc_addr;
        hidx_q[free_slot]  <= alloc_hidx;
      end
      if (cm_valid) begin
        live_q[cm_slot]  <= 1'b0;
        upd_q[cm_slot]   <= 1'b0;
        spec_q[cm_slot]  <= 1'b0;
        blk_q[cm_slot]   <= 1'b0;
        clash_q[cm_slot] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/memdep_pred.sv
`timescale 1ns/1ps
module memdep_pred #(
  parameter int IP_W   = ldp_pkg::LDP_IP_W,
  parameter int IDX_W  = ldp_pkg::LDP_IDX_W,
  parameter int CNT_W  = ldp_pkg::LDP_CNT_W,
  parameter int LB_N   = ldp_pkg::LDP_LB_N,
  parameter int ADDR_W = ldp_pkg::LDP_ADDR_W,
  localparam int SLOT_W = $clog2(LB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_older_unk,
  output logic              ld_rdy,
  output logic [SLOT_W-1:0] ld_slot,
  output logic              ld_go,
  input  logic              st_all_known,
  output logic              rel_valid,
  output logic [SLOT_W-1:0] rel_slot,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LB_N-1:0]   st_ld_mask,
  input  logic              cm_valid,
  input  logic [SLOT_W-1:0] cm_slot,
  output logic              viol_valid,
  output logic [SLOT_W-1:0] viol_slot
);
  logic             tbl_sat;
  logic [IDX_W-1:0] tbl_idx;
  logic             alloc_en;
  logic             train_we;
  logic             cm_update, cm_conflict;
  logic [IDX_W-1:0] cm_hidx;

  assign alloc_en = ld_valid && ld_rdy;
  assign ld_go    = alloc_en && (!ld_older_unk || tbl_sat);
  assign train_we = cm_valid && cm_update;

  ldp_table #(.IP_W(IP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .rd_ip(ld_ip), .rd_idx(tbl_idx), .rd_sat(tbl_sat),
    .wr_en(train_we), .wr_idx(cm_hidx), .wr_clear(cm_conflict)
  );

  ldp_lbuf #(.LB_N(LB_N), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) lbuf_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_addr(ld_addr), .alloc_hidx(tbl_idx),
    .alloc_unk(ld_older_unk), .alloc_go(ld_go),
    .free_any(ld_rdy), .free_slot(ld_slot),
    .rel_en(st_all_known), .rel_valid(rel_valid), .rel_slot(rel_slot),
    .st_valid(st_valid), .st_addr(st_addr), .st_mask(st_ld_mask),
    .viol_valid(viol_valid), .viol_slot(viol_slot),
    .cm_valid(cm_valid), .cm_slot(cm_slot),
    .cm_update(cm_update), .cm_conflict(cm_conflict), .cm_hidx(cm_hidx)
  );
endmodule

// File: rtl/memdep_pred_chk.sv
`timescale 1ns/1ps
module memdep_pred_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_valid,
  input logic ld_older_unk,
  input logic ld_rdy,
  input logic ld_go,
  input logic tbl_sat,
  input logic st_all_known,
  input logic rel_valid,
  input logic st_valid,
  input logic viol_valid,
  input logic cm_valid,
  input logic train_we
);
  AST_GO_NEEDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go && ld_older_unk |-> tbl_sat); // R5
  AST_NOUNK_GOES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_rdy && !ld_older_unk |-> ld_go); // R3
  AST_BLOCK_UNSAT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_older_unk && !tbl_sat |-> !ld_go); // R4
  AST_REL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> st_all_known); // R4
  AST_VIOL_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(st_valid)); // R7
  AST_TRAIN_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    train_we |-> cm_valid); // R10
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> ld_rdy); // R9
endmodule

bind memdep_pred memdep_pred_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_older_unk(ld_older_unk),
  .ld_rdy(ld_rdy), .ld_go(ld_go), .tbl_sat(tbl_sat), .st_all_known(st_all_known),
  .rel_valid(rel_valid), .st_valid(st_valid), .viol_valid(viol_valid),
  .cm_valid(cm_valid), .train_we(train_we)
);

// File: tb/memdep_pred_tb_top.sv
`timescale 1ns/1ps
module memdep_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [11:0] ld_ip = '0;
  logic [31:0] ld_addr = '0;
  logic        ld_older_unk = 1'b0;
  logic        ld_rdy, ld_go;
  logic [2:0]  ld_slot;
  logic        st_all_known = 1'b0;
  logic        rel_valid;
  logic [2:0]  rel_slot;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [7:0]  st_ld_mask = '0;
  logic        cm_valid = 1'b0;
  logic [2:0]  cm_slot = '0;
  logic        viol_valid;
  logic [2:0]  viol_slot;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  memdep_pred dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] ip, input logic [31:0] addr,
                       input logic unk, output int slot, output int go);
    ld_valid = 1'b1; ld_ip = ip; ld_addr = addr; ld_older_unk = unk;
    #1;
    slot = int'(ld_slot); go = int'(ld_go);
    @(negedge clk);
    ld_valid = 1'b0; ld_older_unk = 1'b0;
  endtask

  task automatic release1(output int ok, output int slot);
    st_all_known = 1'b1;
    #1;
    ok = int'(rel_valid); slot = int'(rel_slot);
    @(negedge clk);
    st_all_known = 1'b0;
  endtask

  task automatic commit(input int slot);
    cm_valid = 1'b1; cm_slot = 3'(slot);
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic store(input logic [31:0] addr, input logic [7:0] mask,
                       output int vv, output int vs);
    st_valid = 1'b1; st_addr = addr; st_ld_mask = mask;
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    vv = int'(viol_valid); vs = int'(viol_slot);
  endtask

  // one trained instance per step: issue with unknown store, release if blocked, commit
  task automatic train(input logic [11:0] ip, input int n);
    int s, g, ok, rs;
    for (int k = 0; k < n; k++) begin
      issue(ip, 32'h1000, 1'b1, s, g);
      if (g == 0) release1(ok, rs);
      commit(s);
    end
  endtask

  task automatic t_reset();
    int s, g;
    check("R1 ld_rdy", int'(ld_rdy), 1);
    check("R1 ld_slot", int'(ld_slot), 0);
    check("R1 viol_valid", int'(viol_valid), 0);
    st_all_known = 1'b1; #1;
    check("R1 rel_valid empty", int'(rel_valid), 0);
    st_all_known = 1'b0;
    @(negedge clk);
    issue(12'h7A3, 32'h40, 1'b1, s, g);
    check("R1 counter zero go", g, 0);
    begin int ok, rs; release1(ok, rs); end
    commit(s);
  endtask

  task automatic t_saturate();
    int s, g, ok, rs;
    train(12'h041, 14);
    issue(12'h041, 32'h10, 1'b1, s, g);
    check("R6 at 14 still blocked", g, 0);
    release1(ok, rs);
    check("R4 release valid", ok, 1);
    check("R4 release slot", rs, s);
    commit(s);
    issue(12'h041, 32'h10, 1'b1, s, g);
    check("R5 saturated go", g, 1);
    commit(s);
    issue(12'h041, 32'h10, 1'b1, s, g);
    check("R6 stays at 15", g, 1);
    commit(s);
    issue(12'h000, 32'h10, 1'b1, s, g);
    check("R2 alias shares counter", g, 1);
    commit(s);
    issue(12'h001, 32'h10, 1'b1, s, g);
    check("R2 other index blocked", g, 0);
    release1(ok, rs);
    commit(s);
  endtask

  task automatic t_nounk();
    int s, g, ok, rs;
    train(12'h005, 14);
    issue(12'h005, 32'h20, 1'b0, s, g);
    check("R3 no unknown store goes", g, 1);
    commit(s);
    issue(12'h005, 32'h20, 1'b1, s, g);
    check("R3 commit left counter at 14", g, 0);
    release1(ok, rs);
    commit(s);
  endtask

  task automatic t_release_order();
    int s0, s1, s2, g, ok, rs;
    issue(12'h009, 32'h30, 1'b1, s0, g);
    issue(12'h009, 32'h34, 1'b1, s1, g);
    issue(12'h009, 32'h38, 1'b1, s2, g);
    #1;
    check("R4 no release while unknown", int'(rel_valid), 0);
    release1(ok, rs); check("R4 first release", rs, s0);
    release1(ok, rs); check("R4 second release", rs, s1);
    release1(ok, rs); check("R4 third release", rs, s2);
    release1(ok, rs); check("R4 nothing left", ok, 0);
    commit(s0); commit(s1); commit(s2);
  endtask

  task automatic t_violation();
    int s0, s1, s2, s3, g, vv, vs, ok, rs, sx;
    issue(12'h041, 32'h100, 1'b1, s0, g);
    issue(12'h041, 32'h100, 1'b1, s1, g);
    issue(12'h041, 32'h200, 1'b1, s2, g);
    issue(12'h009, 32'h100, 1'b1, s3, g);
    store(32'h300, 8'hFF, vv, vs);
    check("R7 mismatch no violation", vv, 0);
    store(32'h200, ~(8'h1 << s2), vv, vs);
    check("R7 masked out no violation", vv, 0);
    store(32'h100, 8'hFF, vv, vs);
    check("R7 violation raised", vv, 1);
    check("R7 lowest hit slot", vs, s0);
    @(negedge clk); #1;
    check("R7 one-cycle pulse", int'(viol_valid), 0);
    release1(ok, rs);
    commit(s3);
    commit(s2);
    issue(12'h041, 32'h500, 1'b1, sx, g);
    check("R7 masked load kept counter", g, 1);
    commit(sx);
    commit(s1);
    commit(s0);
    issue(12'h041, 32'h500, 1'b1, sx, g);
    check("R8 conflict cleared counter", g, 0);
    release1(ok, rs);
    commit(sx);
  endtask

  task automatic t_fill();
    int s, g;
    for (int k = 0; k < 8; k++) begin
      issue(12'h0F0, 32'h800 + 32'(k), 1'b0, s, g);
      check("R9 lowest free slot", s, k);
    end
    #1;
    check("R9 full not ready", int'(ld_rdy), 0);
    commit(3);
    #1;
    check("R9 ready after commit", int'(ld_rdy), 1);
    check("R9 freed slot reused", int'(ld_slot), 3);
    for (int k = 0; k < 8; k++) if (k != 3) commit(k);
  endtask

  task automatic t_same_cycle();
    int p, q, g, ok, rs, s;
    train(12'h0C0, 14);
    issue(12'h0C0, 32'h40, 1'b1, p, g);
    release1(ok, rs);
    cm_valid = 1'b1; cm_slot = 3'(p);
    ld_valid = 1'b1; ld_ip = 12'h0C0; ld_older_unk = 1'b1;
    #1;
    q = int'(ld_slot);
    check("R10 same-cycle issue sees old count", int'(ld_go), 0);
    @(negedge clk);
    cm_valid = 1'b0; ld_valid = 1'b0; ld_older_unk = 1'b0;
    issue(12'h0C0, 32'h44, 1'b1, s, g);
    check("R10 next issue sees trained count", g, 1);
    release1(ok, rs);
    commit(q); commit(s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_saturate();
    t_nounk();
    t_release_order();
    t_violation();
    t_fill();
    t_same_cycle();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule